// File: doc/BRIEF.md
# Two-Level Global Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It serves a small set of static branches, each named by a short identifier. A global history register holds the resolved directions of the most recent branches, whatever their identifier. That history selects a 2-bit saturating counter in a pattern table, and the counter's upper bit is the prediction. A lookup is combinational. The caller presents an identifier and reads back a taken or not-taken answer in the same cycle.

When a branch resolves, the caller raises the update strobe with the branch identifier and its real direction. On that clock edge the block trains the counter that the pre-update history selects. The new direction then enters the history. A mode input picks how the counters are organised. Per-branch mode gives every identifier a private table indexed by history. Shared mode makes all identifiers index one common table by history alone, so different branches can collide in the same counter. A parameter sets the state every counter takes at reset.

Top module: `twolvl_dir_predictor`

## Requirements
- R1: After reset the history register is all zeros (not-taken). Every counter holds the reset state parameter: 0 = strongly not-taken (default), 1 = weakly not-taken, 2 = weakly taken.
- R2: `lk_taken` is bit 1 of the selected counter and changes in the same cycle as `lk_id`, `shared_mode` or the state. Counter codes are 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken and 3 strongly taken.
- R3: An update with `upd_taken`=1 raises the selected counter by one and saturates at 3.
- R4: An update with `upd_taken`=0 lowers the selected counter by one and saturates at 0.
- R5: An update selects its counter with the history as it was before that edge. After the edge the history is {old bit 0, outcome}: the outcome enters bit 0 and the oldest bit is dropped.
- R6: In per-branch mode (`shared_mode`=0), branch b with history h uses counter b*4+h. Training one branch leaves the predictions of the other branches unchanged.
- R7: In shared mode (`shared_mode`=1), lookups and updates use counter h for every identifier, so the identifier has no effect.
- R8: While `upd_valid` is 0, neither the counters nor the history change, whatever `upd_id` and `upd_taken` carry.
- R9: With the reset state parameter set to weakly taken, every branch first predicts taken. A single not-taken update of a counter makes that counter predict not-taken.
- R10: Changing `shared_mode` keeps all counter contents. The shared table is the same storage as branch 0's private table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| shared_mode | input | 1 | 1 = one table for all branches, 0 = one table per branch |
| lk_id | input | 2 | Identifier of the branch being predicted |
| lk_taken | output | 1 | Prediction for `lk_id`, 1 = taken |
| upd_valid | input | 1 | Apply a training update on this edge |
| upd_id | input | 2 | Identifier of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The outcome streams used are an unbroken taken run on one branch, an unbroken not-taken run, and an alternating taken/not-taken stream. An alternating stream is told apart from a constant one only if the history truly steers the counter index. A period-four loop pattern exercises all four history values. The same streams then run in shared mode over several identifiers, which exposes collisions that per-branch mode must not show. Mode flips in mid-stream check that the counters are kept. Idle cycles with noisy update fields check that nothing trains without the strobe. A long pseudo-random mix follows. Every lookup identifier is compared against a behavioural model on every clock, for both the default reset state and the weakly-taken reset state.

// File: rtl/twolvl_bp_pkg.sv
package twolvl_bp_pkg;

  localparam int CTR_W = 2;

  typedef enum logic [CTR_W-1:0] {
    CTR_STRONG_NT = 2'd0,
    CTR_WEAK_NT   = 2'd1,
    CTR_WEAK_T    = 2'd2,
    CTR_STRONG_T  = 2'd3
  } ctr_state_e;

  // Saturating step of a 2-bit direction counter.
  function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] cur,
                                                input logic taken);
    logic [CTR_W-1:0] nxt;
    if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/twolvl_bp_index.sv
module twolvl_bp_index #(
  parameter int ID_W   = 2,
  parameter int HIST_W = 2,
  localparam int IDX_W = ID_W + HIST_W
) (
  input  logic              shared_mode,
  input  logic [ID_W-1:0]   br_id,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  // Shared mode maps every branch onto the slice that branch 0 owns.
  always_comb begin
    if (shared_mode) idx = {{ID_W{1'b0}}, hist};
    else             idx = {br_id, hist};
  end

endmodule

// File: rtl/twolvl_bp_history.sv
module twolvl_bp_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_q
);

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
  end

  assert_hist_shift_R5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist_q[0] == $past(shift_bit)) &&
                 (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

  assert_hist_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/twolvl_bp_ctr_table.sv
module twolvl_bp_ctr_table
  import twolvl_bp_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int INIT_STATE = 0,
  localparam int DEPTH     = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam logic [CTR_W-1:0] INIT_CTR = CTR_W'(INIT_STATE);

  logic [DEPTH-1:0][CTR_W-1:0] ctr_q;
  logic [CTR_W-1:0]            wr_next;

  assign rd_ctr  = ctr_q[rd_idx];
  assign wr_next = ctr_step(ctr_q[wr_idx], wr_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) ctr_q[e] <= INIT_CTR;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_next;
    end
  end

  assert_ctr_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken) |=> (ctr_q[$past(wr_idx)] >= $past(ctr_q[wr_idx])) &&
                            (ctr_q[$past(wr_idx)] != CTR_STRONG_NT));

  assert_ctr_dec_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken) |=> (ctr_q[$past(wr_idx)] <= $past(ctr_q[wr_idx])) &&
                             (ctr_q[$past(wr_idx)] != CTR_STRONG_T));

  assert_ctr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctr_q));

endmodule

// File: rtl/twolvl_dir_predictor.sv
module twolvl_dir_predictor
  import twolvl_bp_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int HIST_W     = 2,
  parameter int INIT_STATE = 0,
  localparam int IDX_W     = ID_W + HIST_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shared_mode,
  input  logic [ID_W-1:0] lk_id,
  output logic            lk_taken,
  input  logic            upd_valid,
  input  logic [ID_W-1:0] upd_id,
  input  logic            upd_taken
);

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  upd_idx;
  logic [CTR_W-1:0]  lk_ctr;

  twolvl_bp_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(upd_valid),
    .shift_bit(upd_taken), .hist_q(hist)
  );

  twolvl_bp_index #(.ID_W(ID_W), .HIST_W(HIST_W)) u_lk_index (
    .shared_mode(shared_mode), .br_id(lk_id), .hist(hist), .idx(lk_idx)
  );

  twolvl_bp_index #(.ID_W(ID_W), .HIST_W(HIST_W)) u_upd_index (
    .shared_mode(shared_mode), .br_id(upd_id), .hist(hist), .idx(upd_idx)
  );

  twolvl_bp_ctr_table #(.IDX_W(IDX_W), .INIT_STATE(INIT_STATE)) u_table (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_ctr(lk_ctr),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken)
  );

  assign lk_taken = lk_ctr[CTR_W-1];

  // Shared mode: the update slot never depends on the identifier.
  assert_shared_slot_R7: assert property (@(posedge clk) disable iff (rst)
    (shared_mode && upd_valid) |-> (upd_idx[IDX_W-1:HIST_W] == '0));

endmodule

// File: tb/twolvl_dir_predictor_test.sv
`timescale 1ns/1ps
module twolvl_dir_predictor_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       shared_mode;
  logic [1:0] lk_id;
  logic       lk_taken, lk_taken_wt;
  logic       upd_valid;
  logic [1:0] upd_id;
  logic       upd_taken;

  int tests = 0;
  int fails = 0;
  int ref_ctr [16];
  int ref_wt  [16];
  int ref_hist;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  twolvl_dir_predictor uut (
    .clk(clk), .rst(rst), .shared_mode(shared_mode), .lk_id(lk_id),
    .lk_taken(lk_taken), .upd_valid(upd_valid), .upd_id(upd_id),
    .upd_taken(upd_taken)
  );

  twolvl_dir_predictor #(.INIT_STATE(2)) uut_wt (
    .clk(clk), .rst(rst), .shared_mode(shared_mode), .lk_id(lk_id),
    .lk_taken(lk_taken_wt), .upd_valid(upd_valid), .upd_id(upd_id),
    .upd_taken(upd_taken)
  );

  function automatic int slot(input logic sm, input int id, input int h);
    return sm ? h : id * 4 + h;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: lk_id=%0d hist=%0d got %0b expected %0b",
               tag, lk_id, ref_hist, act, exp);
    end
  endtask

  // Called at a negedge: check all lookups, then model the next edge.
  task automatic step(input string tag, input logic sm, input logic uv,
                      input int uid, input logic ut);
    int s;
    shared_mode = sm; upd_valid = uv; upd_id = 2'(uid); upd_taken = ut;
    for (int i = 0; i < 4; i++) begin
      lk_id = 2'(i);
      #0.5;
      s = slot(sm, i, ref_hist);
      chk({tag, " R2"}, lk_taken, ref_ctr[s] >= 2);
      chk({tag, " R9"}, lk_taken_wt, ref_wt[s] >= 2);
    end
    @(posedge clk);
    if (uv) begin
      s = slot(sm, uid, ref_hist);
      if (ut) begin
        if (ref_ctr[s] < 3) ref_ctr[s]++;
        if (ref_wt[s] < 3)  ref_wt[s]++;
      end else begin
        if (ref_ctr[s] > 0) ref_ctr[s]--;
        if (ref_wt[s] > 0)  ref_wt[s]--;
      end
      ref_hist = ((ref_hist << 1) | int'(ut)) & 3;
    end
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; shared_mode = 1'b0; lk_id = '0;
    upd_valid = 1'b0; upd_id = '0; upd_taken = 1'b0;
    for (int i = 0; i < 16; i++) begin ref_ctr[i] = 0; ref_wt[i] = 2; end
    ref_hist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state seen from both modes
    step("R1 reset per-branch", 1'b0, 1'b0, 0, 1'b0);
    step("R1 reset shared", 1'b1, 1'b0, 0, 1'b0);

    // R3: long taken run on branch 1, saturating high
    for (int k = 0; k < 8; k++) step("R3 taken run", 1'b0, 1'b1, 1, 1'b1);
    // R4: long not-taken run on branch 1, saturating low
    for (int k = 0; k < 8; k++) step("R4 not-taken run", 1'b0, 1'b1, 1, 1'b0);
    // R5: alternating stream on branch 2 separates history slots
    for (int k = 0; k < 12; k++) step("R5 alternate", 1'b0, 1'b1, 2, k[0]);
    // R6: loop pattern TTTN on branch 3, others must stay untouched
    for (int k = 0; k < 16; k++) step("R6 loop", 1'b0, 1'b1, 3, (k % 4) != 3);
    // R8: noisy update fields with strobe low
    for (int k = 0; k < 6; k++) step("R8 idle", 1'b0, 1'b0, k % 4, k[0]);
    // R7: shared mode, several branches collide in one table
    for (int k = 0; k < 16; k++) step("R7 shared", 1'b1, 1'b1, k % 4, (k % 3) != 0);
    // R10: flip mode mid-stream, contents kept
    for (int k = 0; k < 12; k++) step("R10 mode flip", k[1], 1'b1, (k * 3) % 4, k[2]);
    step("R8 idle shared", 1'b1, 1'b0, 2, 1'b1);

    // Pseudo-random mix over everything
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R6 R7 random", lfsr[0], lfsr[1] | lfsr[2], int'(lfsr[4:3]), lfsr[5]);
    end

    // R1: reset again in the middle of activity
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin ref_ctr[i] = 0; ref_wt[i] = 2; end
    ref_hist = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    step("R1 re-reset", 1'b0, 1'b0, 0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule